// File: doc/BRIEF.md
# Aliased Multi-Width General Register File

This block holds eight 32-bit general registers and lets each access name a narrower slice of the same storage. Registers 0 to 3 are data registers: they can be reached as the full 32 bits, as the low 16-bit half, or as either byte of that half. Registers 4 to 7 are pointer/index registers: they can be reached only as the full 32 bits or as the low 16-bit half.

There are two combinational read ports and one synchronous write port. Every port carries a register index, a size code and a high/low byte select. A narrow write merges into the stored register and leaves every other bit untouched. A narrow read returns its slice at bit 0, with zeros above it. An access that names a slice the register does not have is flagged on that port. Such a write is dropped, and such a read returns zero.

Top module: `arf_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears all eight registers to zero.
- R2: The size code 2'b10 selects the full 32 bits. Such a write replaces the whole register, and such a read returns it unchanged, for all eight indices.
- R3: The size code 2'b01 selects bits 15:0. Such a write changes only bits 15:0 of the target, and such a read returns bits 15:0 with bits 31:16 forced to zero, for all eight indices.
- R4: The size code 2'b00 selects a byte of registers 0 to 3. With hi=0 a write changes only bits 7:0, and with hi=1 only bits 15:8. The byte always comes from bits 7:0 of the write data.
- R5: A byte read of registers 0 to 3 returns bits 7:0 (hi=0) or bits 15:8 (hi=1) on bits 7:0 of the read data, with bits 31:8 zero.
- R6: A byte access to registers 4 to 7 raises the illegal flag of its port. Such a write changes no register, and such a read returns zero.
- R7: The size code 2'b11 is reserved for every index. It raises the illegal flag of its port, is never written, and reads as zero.
- R8: Reads are combinational from stored state. A read of the register being written in the same cycle returns the value from before the write, and the new value is visible after the clock edge.
- R9: The two read ports are independent: each one decodes its own index, size and select in the same cycle.
- R10: While wr_en is low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size code: 00 byte, 01 word, 10 dword, 11 reserved |
| wr_hi | input | 1 | Byte select for writes, 1 selects bits 15:8 |
| wr_data | input | 32 | Write data; a narrow write takes its low bits |
| wr_illegal | output | 1 | Write access names a slice that does not exist |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 byte select |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 access is illegal |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 byte select |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 access is illegal |

## Verification
Stored state is visible only through the read ports, so a wrong merge shows up first as a clobbered neighbouring byte or upper half. It appears on the next read of that register in any width, and may stay hidden for many cycles until a full-width read exposes it. The bench reads two registers every cycle and compares them against a model, so corruption is usually caught within a few cycles of the write that caused it. A write that is not suppressed on an illegal access corrupts state in the same way. A port that fails to zero-extend or fails to zero an illegal read shows wrong data in the very cycle of the access.

// File: rtl/arf_pkg.sv
package arf_pkg;

    localparam int ARF_XLEN       = 32;
    localparam int ARF_NREG       = 8;
    localparam int ARF_NBYTE_REGS = 4;
    localparam int ARF_BYTE       = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } size_e;

endpackage

// File: rtl/arf_access_check.sv
module arf_access_check
    import arf_pkg::*;
#(
    parameter int NREG       = ARF_NREG,
    parameter int NBYTE_REGS = ARF_NBYTE_REGS,
    localparam int IDXW      = $clog2(NREG)
) (
    input  logic [IDXW-1:0] idx,
    input  logic [1:0]      size,
    output logic            illegal
);

    logic byte_capable;

    always_comb begin
        byte_capable = (32'(idx) < NBYTE_REGS);
        unique case (size_e'(size))
            SZ_BYTE:  illegal = !byte_capable;
            SZ_WORD:  illegal = 1'b0;
            SZ_DWORD: illegal = 1'b0;
            default:  illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/arf_read_port.sv
module arf_read_port
    import arf_pkg::*;
#(
    parameter int XLEN  = ARF_XLEN,
    parameter int NREG  = ARF_NREG,
    localparam int IDXW = $clog2(NREG),
    localparam int HALF = XLEN / 2
) (
    input  logic [NREG-1:0][XLEN-1:0] regs,
    input  logic [IDXW-1:0]           idx,
    input  logic [1:0]                size,
    input  logic                      hi,
    input  logic                      illegal,
    output logic [XLEN-1:0]           data
);

    logic [XLEN-1:0] sel;

    always_comb begin
        sel  = regs[idx];
        data = '0;
        if (!illegal) begin
            unique case (size_e'(size))
                SZ_BYTE: begin
                    if (hi) data[ARF_BYTE-1:0] = sel[2*ARF_BYTE-1:ARF_BYTE];
                    else    data[ARF_BYTE-1:0] = sel[ARF_BYTE-1:0];
                end
                SZ_WORD:  data[HALF-1:0] = sel[HALF-1:0];
                SZ_DWORD: data = sel;
                default:  data = '0;
            endcase
        end
    end

endmodule

// File: rtl/arf_write_merge.sv
module arf_write_merge
    import arf_pkg::*;
#(
    parameter int XLEN  = ARF_XLEN,
    localparam int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wdata,
    input  logic [1:0]      size,
    input  logic            hi,
    output logic [XLEN-1:0] merged
);

    always_comb begin
        merged = old_val;
        unique case (size_e'(size))
            SZ_BYTE: begin
                if (hi) merged[2*ARF_BYTE-1:ARF_BYTE] = wdata[ARF_BYTE-1:0];
                else    merged[ARF_BYTE-1:0]          = wdata[ARF_BYTE-1:0];
            end
            SZ_WORD:  merged[HALF-1:0] = wdata[HALF-1:0];
            SZ_DWORD: merged = wdata;
            default:  merged = old_val;
        endcase
    end

endmodule

// File: rtl/arf_regfile.sv
module arf_regfile
    import arf_pkg::*;
#(
    parameter int XLEN       = ARF_XLEN,
    parameter int NREG       = ARF_NREG,
    parameter int NBYTE_REGS = ARF_NBYTE_REGS,
    localparam int IDXW      = $clog2(NREG),
    localparam int NRD       = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [1:0]      wr_size,
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_illegal,
    input  logic [IDXW-1:0] rd0_idx,
    input  logic [1:0]      rd0_size,
    input  logic            rd0_hi,
    output logic [XLEN-1:0] rd0_data,
    output logic            rd0_illegal,
    input  logic [IDXW-1:0] rd1_idx,
    input  logic [1:0]      rd1_size,
    input  logic            rd1_hi,
    output logic [XLEN-1:0] rd1_data,
    output logic            rd1_illegal
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } state_t;

    state_t st_d, st_q;

    // write path
    logic [XLEN-1:0] wr_merged;

    arf_access_check #(.NREG(NREG), .NBYTE_REGS(NBYTE_REGS)) u_wr_chk (
        .idx     (wr_idx),
        .size    (wr_size),
        .illegal (wr_illegal)
    );

    arf_write_merge #(.XLEN(XLEN)) u_merge (
        .old_val (st_q.regs[wr_idx]),
        .wdata   (wr_data),
        .size    (wr_size),
        .hi      (wr_hi),
        .merged  (wr_merged)
    );

    // read paths, one per port
    logic [NRD-1:0][IDXW-1:0] rp_idx;
    logic [NRD-1:0][1:0]      rp_size;
    logic [NRD-1:0]           rp_hi;
    logic [NRD-1:0]           rp_illegal;
    logic [NRD-1:0][XLEN-1:0] rp_data;

    assign rp_idx  = {rd1_idx,  rd0_idx};
    assign rp_size = {rd1_size, rd0_size};
    assign rp_hi   = {rd1_hi,   rd0_hi};

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        arf_access_check #(.NREG(NREG), .NBYTE_REGS(NBYTE_REGS)) u_chk (
            .idx     (rp_idx[p]),
            .size    (rp_size[p]),
            .illegal (rp_illegal[p])
        );
        arf_read_port #(.XLEN(XLEN), .NREG(NREG)) u_port (
            .regs    (st_q.regs),
            .idx     (rp_idx[p]),
            .size    (rp_size[p]),
            .hi      (rp_hi[p]),
            .illegal (rp_illegal[p]),
            .data    (rp_data[p])
        );
    end

    assign rd0_data    = rp_data[0];
    assign rd1_data    = rp_data[1];
    assign rd0_illegal = rp_illegal[0];
    assign rd1_illegal = rp_illegal[1];

    // next state
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else if (wr_en && !wr_illegal) begin
            st_d.regs[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/arf_regfile_chk.sv
module arf_regfile_chk
    import arf_pkg::*;
#(
    parameter int XLEN       = ARF_XLEN,
    parameter int NREG       = ARF_NREG,
    parameter int NBYTE_REGS = ARF_NBYTE_REGS,
    localparam int IDXW      = $clog2(NREG),
    localparam int HALF      = XLEN / 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [IDXW-1:0]           wr_idx,
    input logic [1:0]                wr_size,
    input logic [XLEN-1:0]           wr_data,
    input logic                      wr_illegal,
    input logic [1:0]                rd0_size,
    input logic [XLEN-1:0]           rd0_data,
    input logic                      rd0_illegal,
    input logic [NREG-1:0][XLEN-1:0] regs
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (regs == '0));

    assert_dword_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == SZ_DWORD)
        |=> regs[$past(wr_idx)] == $past(wr_data));

    assert_word_keeps_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == SZ_WORD)
        |=> regs[$past(wr_idx)][XLEN-1:HALF] == $past(regs[wr_idx][XLEN-1:HALF]));

    assert_word_read_zext_R3: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == SZ_WORD) |-> (rd0_data[XLEN-1:HALF] == '0));

    assert_byte_keeps_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == SZ_BYTE && !wr_illegal)
        |=> regs[$past(wr_idx)][XLEN-1:HALF] == $past(regs[wr_idx][XLEN-1:HALF]));

    assert_byte_read_zext_R5: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == SZ_BYTE) |-> (rd0_data[XLEN-1:ARF_BYTE] == '0));

    assert_ptr_byte_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_size == SZ_BYTE && 32'(wr_idx) >= NBYTE_REGS) |-> wr_illegal);

    assert_illegal_write_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_illegal) |=> $stable(regs));

    assert_illegal_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rd0_illegal |-> (rd0_data == '0));

    assert_rsvd_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_size == SZ_RSVD) |-> wr_illegal);

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

endmodule

bind arf_regfile arf_regfile_chk #(
    .XLEN(XLEN), .NREG(NREG), .NBYTE_REGS(NBYTE_REGS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_size     (wr_size),
    .wr_data     (wr_data),
    .wr_illegal  (wr_illegal),
    .rd0_size    (rd0_size),
    .rd0_data    (rd0_data),
    .rd0_illegal (rd0_illegal),
    .regs        (st_q.regs)
);

// File: tb/tb_arf_regfile.sv
module tb_arf_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_size;
    logic        wr_hi;
    logic [31:0] wr_data;
    logic        wr_illegal;
    logic [2:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_size, rd1_size;
    logic        rd0_hi, rd1_hi;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_illegal, rd1_illegal;

    always #(CLK_PERIOD/2) clk = ~clk;

    arf_regfile dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
        .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
        .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
        .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    logic [31:0] model [8];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic bit legal(logic [2:0] idx, logic [1:0] sz);
        if (sz == 2'b11) return 0;
        if (sz == 2'b00 && idx >= 3'd4) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] idx, logic [1:0] sz, logic hi);
        logic [31:0] m = model[idx];
        if (!legal(idx, sz)) return 32'h0;
        case (sz)
            2'b00:   return hi ? {24'h0, m[15:8]} : {24'h0, m[7:0]};
            2'b01:   return {16'h0, m[15:0]};
            default: return m;
        endcase
    endfunction

    function automatic logic [31:0] exp_merge(logic [31:0] old, logic [31:0] d,
                                              logic [1:0] sz, logic hi);
        logic [31:0] r = old;
        case (sz)
            2'b00:   if (hi) r[15:8] = d[7:0]; else r[7:0] = d[7:0];
            2'b01:   r[15:0] = d[15:0];
            2'b10:   r = d;
            default: r = old;
        endcase
        return r;
    endfunction

    function automatic string tag_for(logic [2:0] idx, logic [1:0] sz);
        if (sz == 2'b11) return "R7";
        if (!legal(idx, sz)) return "R6";
        if (sz == 2'b00) return "R5";
        if (sz == 2'b01) return "R3";
        return "R2";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, check combinational reads, then commit to model
    task automatic cycle(string ctx, logic wen, logic [2:0] widx, logic [1:0] wsz,
                         logic whi, logic [31:0] wdat,
                         logic [2:0] i0, logic [1:0] s0, logic h0,
                         logic [2:0] i1, logic [1:0] s1, logic h1);
        @(negedge clk);
        wr_en = wen; wr_idx = widx; wr_size = wsz; wr_hi = whi; wr_data = wdat;
        rd0_idx = i0; rd0_size = s0; rd0_hi = h0;
        rd1_idx = i1; rd1_size = s1; rd1_hi = h1;
        #1;
        chk({ctx, " R9 port0 ", tag_for(i0, s0)}, rd0_data, exp_read(i0, s0, h0));
        chk({ctx, " R9 port1 ", tag_for(i1, s1)}, rd1_data, exp_read(i1, s1, h1));
        chk({ctx, " flag0 ", tag_for(i0, s0)}, {31'h0, rd0_illegal}, {31'h0, !legal(i0, s0)});
        chk({ctx, " flag1 ", tag_for(i1, s1)}, {31'h0, rd1_illegal}, {31'h0, !legal(i1, s1)});
        chk({ctx, " wflag ", tag_for(widx, wsz)}, {31'h0, wr_illegal}, {31'h0, !legal(widx, wsz)});
        @(posedge clk);
        if (wen && legal(widx, wsz)) model[widx] = exp_merge(model[widx], wdat, wsz, whi);
    endtask

    task automatic read_all(string ctx);
        for (int k = 0; k < 8; k += 2)
            cycle(ctx, 1'b0, 3'd0, 2'b10, 1'b0, 32'h0,
                  3'(k), 2'b10, 1'b0, 3'(k + 1), 2'b10, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_size = 2'b10; wr_hi = 1'b0; wr_data = '0;
        rd0_idx = '0; rd0_size = 2'b10; rd0_hi = 1'b0;
        rd1_idx = '0; rd1_size = 2'b10; rd1_hi = 1'b0;
        for (int k = 0; k < 8; k++) model[k] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_all("R1 reset");

        // R2 full writes to every index
        for (int k = 0; k < 8; k++)
            cycle("R2 fill", 1'b1, 3'(k), 2'b10, 1'b0, 32'hA5A5_0000 | 32'(k * 32'h1111),
                  3'(k), 2'b10, 1'b0, 3'(k), 2'b01, 1'b0);
        read_all("R2 after fill");

        // R4 high and low byte writes keep neighbours
        cycle("R4 hi", 1'b1, 3'd1, 2'b00, 1'b1, 32'hFFFF_FF3C,
              3'd1, 2'b00, 1'b1, 3'd1, 2'b00, 1'b0);
        cycle("R4 lo", 1'b1, 3'd3, 2'b00, 1'b0, 32'h0000_00C7,
              3'd1, 2'b10, 1'b0, 3'd1, 2'b00, 1'b1);
        cycle("R4 check", 1'b0, 3'd0, 2'b10, 1'b0, 32'h0,
              3'd3, 2'b10, 1'b0, 3'd3, 2'b00, 1'b0);

        // R3 word write to a pointer register keeps upper half
        cycle("R3 word", 1'b1, 3'd6, 2'b01, 1'b1, 32'hDEAD_BEEF,
              3'd6, 2'b10, 1'b0, 3'd6, 2'b01, 1'b0);
        cycle("R3 check", 1'b0, 3'd0, 2'b10, 1'b0, 32'h0,
              3'd6, 2'b10, 1'b0, 3'd6, 2'b01, 1'b0);

        // R6 byte write to pointer register is dropped
        cycle("R6 ptr byte", 1'b1, 3'd5, 2'b00, 1'b0, 32'h0000_0099,
              3'd5, 2'b00, 1'b1, 3'd5, 2'b10, 1'b0);
        cycle("R6 check", 1'b0, 3'd0, 2'b10, 1'b0, 32'h0,
              3'd5, 2'b10, 1'b0, 3'd7, 2'b00, 1'b0);

        // R7 reserved size is dropped
        cycle("R7 rsvd", 1'b1, 3'd0, 2'b11, 1'b0, 32'h1234_5678,
              3'd0, 2'b11, 1'b0, 3'd4, 2'b11, 1'b1);
        cycle("R7 check", 1'b0, 3'd0, 2'b10, 1'b0, 32'h0,
              3'd0, 2'b10, 1'b0, 3'd4, 2'b10, 1'b0);

        // R10 wr_en low ignores write inputs
        cycle("R10 idle", 1'b0, 3'd2, 2'b10, 1'b0, 32'hFFFF_FFFF,
              3'd2, 2'b10, 1'b0, 3'd2, 2'b00, 1'b1);
        cycle("R10 check", 1'b0, 3'd0, 2'b10, 1'b0, 32'h0,
              3'd2, 2'b10, 1'b0, 3'd2, 2'b01, 1'b0);

        // R8 same-cycle read sees old value, next cycle sees new
        cycle("R8 same", 1'b1, 3'd7, 2'b10, 1'b0, 32'h0BAD_F00D,
              3'd7, 2'b10, 1'b0, 3'd7, 2'b01, 1'b0);
        cycle("R8 next", 1'b0, 3'd0, 2'b10, 1'b0, 32'h0,
              3'd7, 2'b10, 1'b0, 3'd7, 2'b01, 1'b0);

        // constrained random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [2:0] wi = 3'($urandom_range(0, 7));
            logic [1:0] ws = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            logic [2:0] a  = ($urandom_range(0, 3) == 0) ? wi : 3'($urandom_range(0, 7));
            cycle("rand", 1'($urandom_range(0, 3) != 0), wi, ws, 1'($urandom), $urandom,
                  a, 2'($urandom_range(0, 3)), 1'($urandom),
                  3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom));
        end
        read_all("final R2");

        // R1 reset again after random traffic
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 8; k++) model[k] = 32'h0;
        @(negedge clk);
        rst = 1'b0;
        read_all("R1 re-reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule